// File: doc/BRIEF.md
# Gated-Input Splittable Look-Up Table

This block is the logic core of a programmable logic element. K data inputs first pass through a gating layer. A parameter string gives one character per pin, and that character decides the pin's treatment. A pin can go straight through. It can be ANDed with a dedicated mode bit, so it is pinned low when that bit is clear. It can be ORed with a mode bit, so it is pinned high when that bit is set. The gated lines then steer a binary multiplexer tree. The tree's 2^K leaves come from a configuration word, so the block realises any K-input function.

When the splittable variant is chosen, a second output appears. It carries the (K-1)-input function held in the half of the configuration word that the top gated input does not pick. Pinning the top input through its mode bit therefore turns one K-input table into two independent (K-1)-input tables that share the lower inputs. Every configuration port also has a complement companion, as a memory cell naturally supplies. The block is purely combinational.

Top module: `frac_lut`

## Requirements
- R1: `lut_out[0]` equals `cfg[idx]`, where `idx` is the K-bit number formed from the gated select lines, with gated pin 0 as the least significant bit. With the default map `"-0-1"` (written pin 0 first), `idx = {din[3] | mode[1], din[2], din[1] & mode[0], din[0]}`.
- R2: A pin whose map character is `-` reaches its select line unchanged, whatever the mode bits hold.
- R3: For a pin mapped `0`, a clear mode bit drives its select line to 0 and a set mode bit passes the data input.
- R4: For a pin mapped `1`, a set mode bit drives its select line to 1 and a clear mode bit passes the data input.
- R5: Mode bits go to the gated pins in rising pin order, and `-` pins are skipped. Under the default map, `mode[0]` gates pin 1 and `mode[1]` gates pin 3.
- R6: Configuration bit i is leaf i of the tree. A one-hot word with bit i set yields 1 exactly when the gated index equals i.
- R7: With `FRACTURABLE=1`, `lut_out[1]` equals `cfg[{~s[K-1], s[K-2:0]}]`, where s is the gated select vector. This is the half-table the top gated input does not select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | K | Data inputs before gating |
| cfg | input | 2**K | Truth-table word; bit i is tree leaf i |
| cfg_n | input | 2**K | Complement of cfg |
| mode | input | max(1,MODE_W) | Gating bits, one per non-`-` map pin, in pin order |
| mode_n | input | max(1,MODE_W) | Complement of mode |
| lut_out | output | 1+FRACTURABLE | Bit 0 is the full function; bit 1 is the unselected half-table |

## Verification
The block holds no state, so each output is due in the same cycle as the input change that causes it, with zero register stages on the way. The bench changes inputs just after a falling clock edge and compares 2 ns later, well before the next rising edge. It sweeps all 16 input codes under all four mode settings and several truth tables, and checks both outputs against a select index it forms arithmetically from the gating rules. It also runs a one-hot leaf walk and truth tables that isolate single pins.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;

    localparam int MAX_PINS = 16;

    typedef logic [8*MAX_PINS-1:0] gate_map_t;

    // character governing pin 'pin'; first written character belongs to pin 0
    function automatic logic [7:0] pin_char(gate_map_t map, int pins, int pin);
        return map[8*(pins-1-pin) +: 8];
    endfunction

    function automatic bit is_gated(gate_map_t map, int pins, int pin);
        logic [7:0] c;
        c = pin_char(map, pins, pin);
        return (c == "0") || (c == "1");
    endfunction

    // number of gated pins strictly below 'pin' = mode bit slot of 'pin'
    function automatic int mode_slot(gate_map_t map, int pins, int pin);
        int n;
        n = 0;
        for (int i = 0; i < pin; i++) begin
            if (is_gated(map, pins, i)) n++;
        end
        return n;
    endfunction

    function automatic int gated_count(gate_map_t map, int pins);
        return mode_slot(map, pins, pins);
    endfunction

    function automatic bit map_legal(gate_map_t map, int pins);
        bit ok;
        logic [7:0] c;
        ok = 1'b1;
        for (int i = 0; i < pins; i++) begin
            c = pin_char(map, pins, i);
            if ((c != "-") && (c != "0") && (c != "1")) ok = 1'b0;
        end
        return ok;
    endfunction

    // first node index of tree level 'lvl' in a flat heap of 2^(k+1)-1 nodes
    function automatic int level_base(int k, int lvl);
        return (2 ** (k + 1)) - (2 ** (k + 1 - lvl));
    endfunction

endpackage

// File: rtl/lut_gate_layer.sv
module lut_gate_layer
    import frac_lut_pkg::*;
#(
    parameter int              K        = 4,
    parameter int              MW       = 2,
    parameter logic [8*K-1:0]  GATE_MAP = "-0-1"
) (
    input  logic [K-1:0]  din,
    input  logic [MW-1:0] mode,
    output logic [K-1:0]  sel,
    output logic [K-1:0]  sel_n
);

    localparam gate_map_t MAP_X = gate_map_t'(GATE_MAP);

    logic [K-1:0] gated_d;

    for (genvar p = 0; p < K; p++) begin : g_pin
        localparam logic [7:0] CH   = pin_char(MAP_X, K, p);
        localparam int         SLOT = mode_slot(MAP_X, K, p);
        if (CH == "0") begin : g_and
            assign gated_d[p] = din[p] & mode[SLOT];
        end else if (CH == "1") begin : g_or
            assign gated_d[p] = din[p] | mode[SLOT];
        end else begin : g_wire
            assign gated_d[p] = din[p];
        end
        // true and inverted drive of each select line
        assign sel[p]   = gated_d[p];
        assign sel_n[p] = ~gated_d[p];
    end

endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree
    import frac_lut_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [2**K-1:0] leaves,
    input  logic [K-1:0]    sel,
    input  logic [K-1:0]    sel_n,
    output logic            root,
    output logic            half_lo,
    output logic            half_hi
);

    localparam int LEAVES = 2 ** K;
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int TOP    = level_base(K, K);
    localparam int HALF   = level_base(K, K - 1);

    logic [NODES-1:0] node;

    assign node[LEAVES-1:0] = leaves;

    for (genvar l = 1; l <= K; l++) begin : g_lvl
        localparam int SRC = level_base(K, l - 1);
        localparam int DST = level_base(K, l);
        for (genvar n = 0; n < 2 ** (K - l); n++) begin : g_node
            assign node[DST+n] = (sel[l-1]   & node[SRC+2*n+1])
                               | (sel_n[l-1] & node[SRC+2*n]);
        end
    end

    assign root    = node[TOP];
    assign half_lo = node[HALF];
    assign half_hi = node[HALF+1];

endmodule

// File: rtl/frac_lut.sv
module frac_lut
    import frac_lut_pkg::*;
#(
    parameter int              K           = 4,
    parameter bit              FRACTURABLE = 1'b1,
    parameter int              MODE_W      = 2,
    parameter logic [8*K-1:0]  GATE_MAP    = "-0-1",
    localparam int             MW          = (MODE_W < 1) ? 1 : MODE_W,
    localparam int             NOUT        = FRACTURABLE ? 2 : 1
) (
    input  logic [K-1:0]    din,
    input  logic [2**K-1:0] cfg,
    input  logic [2**K-1:0] cfg_n,
    input  logic [MW-1:0]   mode,
    input  logic [MW-1:0]   mode_n,
    output logic [NOUT-1:0] lut_out
);

    localparam gate_map_t MAP_X  = gate_map_t'(GATE_MAP);
    localparam int        GATED  = gated_count(MAP_X, K);

    // elaboration-time legality of the parameter set
    if (K < 2 || K > 12) begin : g_bad_k
        $error("frac_lut: K must lie in 2..12");
    end
    if (!map_legal(MAP_X, K)) begin : g_bad_map
        $error("frac_lut: gate map may hold only '-', '0' and '1'");
    end
    if (GATED != MODE_W) begin : g_bad_mw
        $error("frac_lut: MODE_W must equal the count of gated pins");
    end
    if (!FRACTURABLE && GATED != 0) begin : g_bad_single
        $error("frac_lut: single-output variant takes no gated pins");
    end

    logic [K-1:0] sel;
    logic [K-1:0] sel_n;
    logic         root;
    logic         half_lo;
    logic         half_hi;

    lut_gate_layer #(
        .K        (K),
        .MW       (MW),
        .GATE_MAP (GATE_MAP)
    ) i_gate (
        .din   (din),
        .mode  (mode),
        .sel   (sel),
        .sel_n (sel_n)
    );

    lut_mux_tree #(
        .K (K)
    ) i_tree (
        .leaves  (cfg),
        .sel     (sel),
        .sel_n   (sel_n),
        .root    (root),
        .half_lo (half_lo),
        .half_hi (half_hi)
    );

    assign lut_out[0] = root;

    if (FRACTURABLE) begin : g_split
        // picks the half-table the top select does NOT choose
        assign lut_out[NOUT-1] = (sel[K-1] & half_lo) | (sel_n[K-1] & half_hi);
    end

    // ---------------- assertions ----------------
    for (genvar p = 0; p < K; p++) begin : g_chk
        localparam logic [7:0] CH   = pin_char(MAP_X, K, p);
        localparam int         SLOT = mode_slot(MAP_X, K, p);
        if (CH == "0") begin : g_c0
            always_comb begin
                p_force_low_r3: assert (mode[SLOT] ? (sel[p] == din[p]) : (sel[p] == 1'b0))
                    else $error("R3 gated-low pin %0d wrong", p);
            end
        end else if (CH == "1") begin : g_c1
            always_comb begin
                p_force_high_r4: assert (mode[SLOT] ? (sel[p] == 1'b1) : (sel[p] == din[p]))
                    else $error("R4 gated-high pin %0d wrong", p);
            end
        end else begin : g_cw
            always_comb begin
                p_pass_r2: assert (sel[p] == din[p])
                    else $error("R2 pass pin %0d wrong", p);
            end
        end
    end

    always_comb begin
        p_rail_pair_r1: assert (sel_n == ~sel)
            else $error("R1 select rails disagree");
        p_cfg_pair_r6: assert (cfg_n == ~cfg)
            else $error("R6 configuration complement mismatch");
        p_mode_pair_r5: assert (mode_n == ~mode)
            else $error("R5 mode complement mismatch");
    end

    if (FRACTURABLE) begin : g_split_chk
        always_comb begin
            if (half_lo == half_hi) begin
                p_half_agree_r7: assert (lut_out[NOUT-1] == root)
                    else $error("R7 split output disagrees with equal halves");
            end
        end
    end

endmodule

// File: tb/test_frac_lut.sv
module test_frac_lut;

    localparam int K = 4;

    logic          clk = 1'b0;
    logic [K-1:0]  din  = '0;
    logic [15:0]   cfg  = '0;
    logic [15:0]   cfg_n;
    logic [1:0]    mode = '0;
    logic [1:0]    mode_n;
    logic [1:0]    lut_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    assign cfg_n  = ~cfg;
    assign mode_n = ~mode;

    always #5 clk = ~clk;

    frac_lut #(
        .K           (K),
        .FRACTURABLE (1'b1),
        .MODE_W      (2),
        .GATE_MAP    ("-0-1")
    ) i_frac_lut (
        .din     (din),
        .cfg     (cfg),
        .cfg_n   (cfg_n),
        .mode    (mode),
        .mode_n  (mode_n),
        .lut_out (lut_out)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s din=%b mode=%b cfg=%h actual=%b expected=%b",
                     tag, din, mode, cfg, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] c, logic [1:0] m, logic [3:0] d);
        @(negedge clk);
        cfg  = c;
        mode = m;
        din  = d;
        #2;
    endtask

    // gated select vector from the requirements (map "-0-1")
    function automatic logic [3:0] gsel(logic [3:0] d, logic [1:0] m);
        return {d[3] | m[1], d[2], d[1] & m[0], d[0]};
    endfunction

    initial begin
        // R1: all-zero table gives zero on both outputs
        apply(16'h0000, 2'b00, 4'h0);
        chk("R1 zero table out0", lut_out[0], 1'b0);
        chk("R7 zero table out1", lut_out[1], 1'b0);

        // R1 R3 R4 R7: full sweep of codes and modes over several tables
        for (int t = 0; t < 6; t++) begin
            logic [15:0] c;
            c = 16'hA5C3 ^ (16'h3B17 * t[15:0]) ^ {t[7:0], 8'h5E};
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 16; d++) begin
                    logic [3:0] s;
                    string tag;
                    apply(c, m[1:0], d[3:0]);
                    s = gsel(d[3:0], m[1:0]);
                    if (m[0] == 0 && d[1]) tag = "R3 low-forced out0";
                    else if (m[1] && !d[3]) tag = "R4 high-forced out0";
                    else tag = "R1 sweep out0";
                    chk(tag, lut_out[0], c[s]);
                    chk("R7 split out1", lut_out[1], c[{~s[3], s[2:0]}]);
                end
            end
        end

        // R6: one-hot leaf walk with both gates transparent
        for (int i = 0; i < 16; i++) begin
            apply(16'h1 << i, 2'b01, i[3:0]);
            chk("R6 hit leaf", lut_out[0], 1'b1);
            apply(16'h1 << i, 2'b01, i[3:0] ^ 4'h5);
            chk("R6 miss leaf", lut_out[0], 1'b0);
        end

        // R2: tables depending on one ungated pin follow it under any mode
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 16; d++) begin
                apply(16'hAAAA, m[1:0], d[3:0]);
                chk("R2 pin0 pass", lut_out[0], d[0]);
                apply(16'hF0F0, m[1:0], d[3:0]);
                chk("R2 pin2 pass", lut_out[0], d[2]);
            end
        end

        // R5: mode[0] belongs to pin 1, mode[1] to pin 3
        for (int d = 0; d < 16; d++) begin
            apply(16'hCCCC, 2'b01, d[3:0]);
            chk("R5 mode0 frees pin1", lut_out[0], d[1]);
            apply(16'hFF00, 2'b01, d[3:0]);
            chk("R5 mode0 leaves pin3", lut_out[0], d[3]);
            apply(16'hFF00, 2'b10, d[3:0]);
            chk("R5 mode1 pins pin3", lut_out[0], 1'b1);
            apply(16'hCCCC, 2'b10, d[3:0]);
            chk("R5 mode1 leaves pin1 low", lut_out[0], 1'b0);
        end

        // R7: top pinned high, the two halves act as separate 3-input tables
        for (int d = 0; d < 8; d++) begin
            apply(16'h96E1, 2'b11, {1'b0, d[2:0]});
            chk("R7 upper half out0", lut_out[0], 1'(16'h96E1 >> (8 + d)));
            chk("R7 lower half out1", lut_out[1], 1'(16'h96E1 >> d));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule